// File: doc/BRIEF.md
# YCbCr to RGB Colour-Space Converter

This block turns a stream of 8-bit luma and colour-difference samples into 8-bit red, green and blue values. Each incoming pixel carries Y, Cb and Cr, qualified by a valid strobe. The pixel passes through a three-register pipeline: range handling and gain, then the colour matrix, then rounding and clamping. It comes out with its own valid strobe three clocks later. Cycles with the strobe low are bubbles. They move through the pipeline without disturbing the held output values.

Three static configuration inputs control the conversion. The first selects one of two named input range modes. In RANGE_STUDIO the samples are taken at nominal studio levels: luma black at 16, luma white at 235, chroma centred on 128. In RANGE_FULL the samples use the whole 0 to 255 swing and are compressed onto studio levels before the matrix. The other two inputs are gain trims, one for luma and one shared by both colour-difference channels. The only transition between the two modes is a change of the range input. It takes effect on the next pixel that enters the first stage. Pixels already in flight keep the mode they were captured with.

Top module: `ycc_to_rgb`

## Requirements
- R1: With Y', Cb', Cr' denoting luma and centred chroma after range handling and gain (in units of 1/1024), the outputs are R = Y' + 1404·Cr'/1024, G = Y' − 345·Cb'/1024 − 715·Cr'/1024 and B = Y' + 1774·Cb'/1024. Each is rounded to nearest, with halves rounded upward.
- R2: In studio mode (range input 0), Y' = 1024·Y, Cb' = 1024·(Cb − 128) and Cr' = 1024·(Cr − 128) before gain. With neutral chroma and unity gains, each output equals Y.
- R3: In full-range mode (range input 1), Y' = 16·1024 + 879·Y, Cb' = 900·(Cb − 128) and Cr' = 900·(Cr − 128) before gain. A full-range Y of 255 with neutral chroma gives 235, and a Y of 0 gives 16.
- R4: Gains are unsigned 8-bit values with 128 as unity. The luma gain multiplies Y' and the chroma gain multiplies both Cb' and Cr'. Each product is divided by 128 with an arithmetic right shift, rounding toward minus infinity.
- R5: Each output channel clamps to 0 when the rounded result is negative and to 255 when it exceeds 255.
- R6: out_valid equals in_valid delayed by exactly three clocks. Each pixel's result appears with it.
- R7: In a cycle where out_valid is low, out_r, out_g and out_b keep the values of the last valid output.
- R8: While reset is high, out_valid is 0 and all three colour outputs are 0.
- R9: In studio mode at unity gains, the following four inputs give exact outputs. White (235,128,128) gives (235,235,235). Black (16,128,128) gives (16,16,16). Yellow (210,16,146) gives (235,235,16). Blue (41,240,110) gives (16,16,235).
- R10: When Cb and Cr both equal 128, the three outputs are equal in every mode and at every gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel qualifier |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue colour-difference sample, 128-centred |
| in_cr | input | 8 | Red colour-difference sample, 128-centred |
| full_range | input | 1 | 0 selects RANGE_STUDIO, 1 selects RANGE_FULL |
| gain_y | input | 8 | Luma gain, 128 is unity |
| gain_c | input | 8 | Colour-difference gain, 128 is unity |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |

## Verification
Each internal fault shows at the ports as follows.
- A wrong coefficient, offset or shift gives a wrong colour. It appears on the third clock after the pixel enters, and it shows most plainly on the colour-bar points and on neutral grey, where the three channels must agree.
- A register that is misaligned or wrongly enabled in one stage pairs a result with the wrong strobe. It can also corrupt the value held during bubbles. Either error is visible on the first idle or valid cycle that follows.
- A clamp that is missing lets values wrap around. This shows at once on the sweep points that drive results past 0 or 255.

The sweeps cover luma, both chroma channels and four range-and-gain settings. Bubbles are inserted at regular intervals, so each of these faults is caught within a few cycles of its first occurrence.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    typedef enum logic {
        RANGE_STUDIO = 1'b0,
        RANGE_FULL   = 1'b1
    } range_mode_e;

    // All coefficients carry COEF_FRAC fractional bits
    localparam int COEF_FRAC  = 10;
    localparam int K_CR_TO_R  = 1404;
    localparam int K_CB_TO_G  = 345;
    localparam int K_CR_TO_G  = 715;
    localparam int K_CB_TO_B  = 1774;

    // Full-swing compression factors and studio black level
    localparam int K_FULL_Y   = 879;
    localparam int K_FULL_C   = 900;
    localparam int BLACK_LVL  = 16;

endpackage

// File: rtl/ycc_range_gain.sv
module ycc_range_gain
    import ycc_pkg::*;
#(
    parameter int DW     = 8,
    parameter int GAIN_W = 8,
    localparam int G_W   = DW + COEF_FRAC + 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  full_range,
    input  logic [DW-1:0]         y,
    input  logic [DW-1:0]         cb,
    input  logic [DW-1:0]         cr,
    input  logic [GAIN_W-1:0]     gain_y,
    input  logic [GAIN_W-1:0]     gain_c,
    output logic                  vld,
    output logic signed [G_W-1:0] yq,
    output logic signed [G_W-1:0] cbq,
    output logic signed [G_W-1:0] crq
);

    localparam int S_W = DW + COEF_FRAC + 2;
    localparam int P_W = S_W + GAIN_W + 1;
    localparam logic signed [S_W-1:0] MID     = S_W'(1 << (DW - 1));
    localparam logic signed [S_W-1:0] BLACK_Q = S_W'(BLACK_LVL << COEF_FRAC);
    localparam logic signed [S_W-1:0] KFY     = S_W'(K_FULL_Y);
    localparam logic signed [S_W-1:0] KFC     = S_W'(K_FULL_C);
    localparam logic [GAIN_W-1:0]     UNITY   = GAIN_W'(1 << (GAIN_W - 1));

    range_mode_e mode;
    logic signed [S_W-1:0] y_ext, cb_ext, cr_ext;
    logic signed [S_W-1:0] ys, cbs, crs;

    assign mode   = range_mode_e'(full_range);
    assign y_ext  = $signed({{(S_W-DW){1'b0}}, y});
    assign cb_ext = $signed({{(S_W-DW){1'b0}}, cb}) - MID;
    assign cr_ext = $signed({{(S_W-DW){1'b0}}, cr}) - MID;

    always_comb begin
        unique case (mode)
            RANGE_STUDIO: begin
                ys  = y_ext  <<< COEF_FRAC;
                cbs = cb_ext <<< COEF_FRAC;
                crs = cr_ext <<< COEF_FRAC;
            end
            RANGE_FULL: begin
                ys  = BLACK_Q + y_ext * KFY;
                cbs = cb_ext * KFC;
                crs = cr_ext * KFC;
            end
            default: begin
                ys  = '0;
                cbs = '0;
                crs = '0;
            end
        endcase
    end

    function automatic logic signed [G_W-1:0] scale(
        input logic signed [S_W-1:0] v,
        input logic [GAIN_W-1:0]     g
    );
        logic signed [P_W-1:0] p;
        p = P_W'(v) * $signed({{(P_W-GAIN_W){1'b0}}, g});
        return G_W'(p >>> (GAIN_W - 1));
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
            yq  <= '0;
            cbq <= '0;
            crq <= '0;
        end else begin
            vld <= en;
            if (en) begin
                yq  <= scale(ys,  gain_y);
                cbq <= scale(cbs, gain_c);
                crq <= scale(crs, gain_c);
            end
        end
    end

    // R2 / R4: studio luma at unity gain lands unchanged in Q10
    assert_unity_luma_R4: assert property (@(posedge clk) disable iff (rst)
        (en && !full_range && gain_y == UNITY)
        |=> (yq == ($signed({{(G_W-DW){1'b0}}, $past(y)}) <<< COEF_FRAC)));

endmodule

// File: rtl/ycc_matrix.sv
module ycc_matrix
    import ycc_pkg::*;
#(
    parameter int DW    = 8,
    parameter int ACC_W = 34,
    localparam int G_W  = DW + COEF_FRAC + 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [G_W-1:0]   yq,
    input  logic signed [G_W-1:0]   cbq,
    input  logic signed [G_W-1:0]   crq,
    output logic                    vld,
    output logic signed [ACC_W-1:0] acc_r,
    output logic signed [ACC_W-1:0] acc_g,
    output logic signed [ACC_W-1:0] acc_b
);

    localparam logic signed [ACC_W-1:0] KR  = ACC_W'(K_CR_TO_R);
    localparam logic signed [ACC_W-1:0] KGB = ACC_W'(K_CB_TO_G);
    localparam logic signed [ACC_W-1:0] KGR = ACC_W'(K_CR_TO_G);
    localparam logic signed [ACC_W-1:0] KB  = ACC_W'(K_CB_TO_B);

    logic signed [ACC_W-1:0] y_w, cb_w, cr_w;
    logic signed [ACC_W-1:0] sum_r, sum_g, sum_b;

    assign y_w  = ACC_W'(yq) <<< COEF_FRAC;
    assign cb_w = ACC_W'(cbq);
    assign cr_w = ACC_W'(crq);

    always_comb begin
        sum_r = y_w + KR * cr_w;
        sum_g = y_w - KGB * cb_w - KGR * cr_w;
        sum_b = y_w + KB * cb_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld   <= 1'b0;
            acc_r <= '0;
            acc_g <= '0;
            acc_b <= '0;
        end else begin
            vld <= en;
            if (en) begin
                acc_r <= sum_r;
                acc_g <= sum_g;
                acc_b <= sum_b;
            end
        end
    end

    // R10: zero chroma leaves the three channel sums identical
    assert_grey_equal_R10: assert property (@(posedge clk) disable iff (rst)
        (en && cbq == '0 && crq == '0)
        |=> (acc_r == acc_g && acc_g == acc_b));

endmodule

// File: rtl/ycc_clamp.sv
module ycc_clamp
    import ycc_pkg::*;
#(
    parameter int DW    = 8,
    parameter int ACC_W = 34
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] acc,
    output logic [DW-1:0]           q
);

    localparam int SHIFT = 2 * COEF_FRAC;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (SHIFT - 1));
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< DW) - 1);
    localparam logic signed [ACC_W-1:0] OVER = ACC_W'(64'sd1 <<< (SHIFT + DW));

    logic signed [ACC_W-1:0] rounded;
    logic [DW-1:0]           q_next;

    assign rounded = (acc + HALF) >>> SHIFT;

    always_comb begin
        if (rounded < 0)
            q_next = '0;
        else if (rounded > MAXV)
            q_next = '1;
        else
            q_next = rounded[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= q_next;
    end

    // R5: saturation at both ends
    assert_clamp_low_R5: assert property (@(posedge clk) disable iff (rst)
        (en && acc < -HALF) |=> (q == '0));
    assert_clamp_high_R5: assert property (@(posedge clk) disable iff (rst)
        (en && acc > OVER) |=> (q == '1));

endmodule

// File: rtl/ycc_to_rgb.sv
module ycc_to_rgb
    import ycc_pkg::*;
#(
    parameter int DW     = 8,
    parameter int GAIN_W = 8,
    parameter int ACC_W  = 34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_y,
    input  logic [DW-1:0]     in_cb,
    input  logic [DW-1:0]     in_cr,
    input  logic              full_range,
    input  logic [GAIN_W-1:0] gain_y,
    input  logic [GAIN_W-1:0] gain_c,
    output logic              out_valid,
    output logic [DW-1:0]     out_r,
    output logic [DW-1:0]     out_g,
    output logic [DW-1:0]     out_b
);

    localparam int G_W   = DW + COEF_FRAC + 4;
    localparam int N_CH  = 3;
    localparam logic [DW-1:0]     MID_IN = DW'(1 << (DW - 1));
    localparam logic [GAIN_W-1:0] UNITY  = GAIN_W'(1 << (GAIN_W - 1));

    logic                    v1, v2;
    logic signed [G_W-1:0]   yq, cbq, crq;
    logic signed [ACC_W-1:0] acc_r, acc_g, acc_b;
    logic signed [ACC_W-1:0] acc_ch [N_CH];
    logic [DW-1:0]           q_ch   [N_CH];

    ycc_range_gain #(.DW(DW), .GAIN_W(GAIN_W)) u_stage1 (
        .clk        (clk),
        .rst        (rst),
        .en         (in_valid),
        .full_range (full_range),
        .y          (in_y),
        .cb         (in_cb),
        .cr         (in_cr),
        .gain_y     (gain_y),
        .gain_c     (gain_c),
        .vld        (v1),
        .yq         (yq),
        .cbq        (cbq),
        .crq        (crq)
    );

    ycc_matrix #(.DW(DW), .ACC_W(ACC_W)) u_stage2 (
        .clk   (clk),
        .rst   (rst),
        .en    (v1),
        .yq    (yq),
        .cbq   (cbq),
        .crq   (crq),
        .vld   (v2),
        .acc_r (acc_r),
        .acc_g (acc_g),
        .acc_b (acc_b)
    );

    assign acc_ch[0] = acc_r;
    assign acc_ch[1] = acc_g;
    assign acc_ch[2] = acc_b;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        ycc_clamp #(.DW(DW), .ACC_W(ACC_W)) u_clamp (
            .clk (clk),
            .rst (rst),
            .en  (v2),
            .acc (acc_ch[c]),
            .q   (q_ch[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= v2;
    end

    assign out_r = q_ch[0];
    assign out_g = q_ch[1];
    assign out_b = q_ch[2];

    // R6: three-clock strobe latency
    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid, 3));

    // R7: outputs frozen on bubbles
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_r) && $stable(out_g) && $stable(out_b)));

    // R10: neutral chroma in gives grey out
    assert_grey_out_R10: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && in_cb == MID_IN && in_cr == MID_IN, 3)
        |-> (out_r == out_g && out_g == out_b));

    // R2: studio grey at unity gains reproduces luma
    assert_studio_pass_R2: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && !full_range && gain_y == UNITY && gain_c == UNITY
              && in_cb == MID_IN && in_cr == MID_IN, 3)
        |-> (out_r == $past(in_y, 3)));

endmodule

// File: tb/ycc_to_rgb_bench.sv
module ycc_to_rgb_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_y = '0, in_cb = '0, in_cr = '0;
    logic       full_range = 1'b0;
    logic [7:0] gain_y = 8'd128, gain_c = 8'd128;
    logic       out_valid;
    logic [7:0] out_r, out_g, out_b;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // expected-result history, index 0 = driven one negedge ago
    bit    hv [3];
    int    hr [3], hg [3], hb [3];
    string ht [3];
    int    last_r = 0, last_g = 0, last_b = 0;

    always #4 clk = ~clk;

    ycc_to_rgb u_ycc_to_rgb (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_y       (in_y),
        .in_cb      (in_cb),
        .in_cr      (in_cr),
        .full_range (full_range),
        .gain_y     (gain_y),
        .gain_c     (gain_c),
        .out_valid  (out_valid),
        .out_r      (out_r),
        .out_g      (out_g),
        .out_b      (out_b)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int got, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int round_sat(input longint acc);
        longint t;
        t = (acc + 64'sd524288) >>> 20;
        if (t < 0)   return 0;
        if (t > 255) return 255;
        return int'(t);
    endfunction

    // R1..R5 arithmetic model
    task automatic model(input int y, input int cb, input int cr,
                         output int r, output int g, output int b);
        longint ys, cbs, crs, yg, cbg, crg;
        if (full_range) begin
            ys  = 64'(16 * 1024 + y * 879);
            cbs = 64'((cb - 128) * 900);
            crs = 64'((cr - 128) * 900);
        end else begin
            ys  = 64'(y * 1024);
            cbs = 64'((cb - 128) * 1024);
            crs = 64'((cr - 128) * 1024);
        end
        yg  = (ys  * longint'(gain_y)) >>> 7;
        cbg = (cbs * longint'(gain_c)) >>> 7;
        crg = (crs * longint'(gain_c)) >>> 7;
        r = round_sat((yg <<< 10) + 1404 * crg);
        g = round_sat((yg <<< 10) - 345 * cbg - 715 * crg);
        b = round_sat((yg <<< 10) + 1774 * cbg);
    endtask

    task automatic check_out();
        if (hv[2]) begin
            chk(out_valid == 1'b1, "R6", "out_valid high", int'(out_valid), 1);
            chk(int'(out_r) == hr[2], ht[2], "red",   int'(out_r), hr[2]);
            chk(int'(out_g) == hg[2], ht[2], "green", int'(out_g), hg[2]);
            chk(int'(out_b) == hb[2], ht[2], "blue",  int'(out_b), hb[2]);
            last_r = hr[2]; last_g = hg[2]; last_b = hb[2];
        end else begin
            chk(out_valid == 1'b0, "R6", "out_valid low", int'(out_valid), 0);
            chk(int'(out_r) == last_r, "R7", "held red",   int'(out_r), last_r);
            chk(int'(out_g) == last_g, "R7", "held green", int'(out_g), last_g);
            chk(int'(out_b) == last_b, "R7", "held blue",  int'(out_b), last_b);
        end
    endtask

    task automatic step(input bit v, input int y, input int cb, input int cr,
                        input string tag);
        int r, g, b;
        @(negedge clk);
        check_out();
        for (int i = 2; i > 0; i--) begin
            hv[i] = hv[i-1]; hr[i] = hr[i-1]; hg[i] = hg[i-1];
            hb[i] = hb[i-1]; ht[i] = ht[i-1];
        end
        in_valid = v;
        in_y  = 8'(y);
        in_cb = 8'(cb);
        in_cr = 8'(cr);
        model(y, cb, cr, r, g, b);
        hv[0] = v; hr[0] = r; hg[0] = g; hb[0] = b; ht[0] = tag;
    endtask

    task automatic direct(input int y, input int cb, input int cr,
                          input int er, input int eg, input int eb,
                          input string tag);
        step(1'b1, y, cb, cr, tag);
        for (int i = 0; i < 3; i++) step(1'b0, 0, 0, 0, tag);
        chk(int'(out_r) == er, tag, "fixed red",   int'(out_r), er);
        chk(int'(out_g) == eg, tag, "fixed green", int'(out_g), eg);
        chk(int'(out_b) == eb, tag, "fixed blue",  int'(out_b), eb);
    endtask

    task automatic sweep(input bit fr, input int gy, input int gc,
                         input string tag);
        int cyc = 0;
        for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, tag);
        full_range = fr;
        gain_y = 8'(gy);
        gain_c = 8'(gc);
        for (int y = 0; y < 256; y += 5)
            for (int cb = 0; cb < 256; cb += 15)
                for (int cr = 0; cr < 256; cr += 15) begin
                    if (cyc % 7 == 6) step(1'b0, 0, 0, 0, tag);
                    step(1'b1, y, cb, cr, tag);
                    cyc++;
                end
        for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; hr[i] = 0; hg[i] = 0; hb[i] = 0; ht[i] = "R6";
        end
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(out_valid == 1'b0, "R8", "reset valid", int'(out_valid), 0);
        chk(out_r == 8'd0, "R8", "reset red",   int'(out_r), 0);
        chk(out_g == 8'd0, "R8", "reset green", int'(out_g), 0);
        chk(out_b == 8'd0, "R8", "reset blue",  int'(out_b), 0);
        rst = 1'b0;

        // R9 colour-bar points, studio unity
        direct(235, 128, 128, 235, 235, 235, "R9");
        direct(16,  128, 128, 16,  16,  16,  "R9");
        direct(210, 16,  146, 235, 235, 16,  "R9");
        direct(41,  240, 110, 16,  16,  235, "R9");
        // R5 saturation, R1 rounding
        direct(255, 128, 255, 255, 166, 255, "R5");
        direct(0,   128, 0,   0,   89,  0,   "R5");
        // R3 full-range end points
        full_range = 1'b1;
        direct(255, 128, 128, 235, 235, 235, "R3");
        direct(0,   128, 128, 16,  16,  16,  "R3");
        // R4 half luma gain
        full_range = 1'b0;
        gain_y = 8'd64;
        direct(200, 128, 128, 100, 100, 100, "R4");
        gain_y = 8'd128;

        sweep(1'b0, 128, 128, "R2");
        sweep(1'b1, 128, 128, "R3");
        sweep(1'b0, 200, 64,  "R4");
        sweep(1'b1, 100, 255, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule